// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a virtual address into a physical address by reading a tree of page tables that sits in physical memory. A requester hands it a virtual address together with the physical address of the root table for the current process. The walker then reads one table entry per level over a simple memory read port. Each entry it reads either points to the next table or, at the last level, names the physical page.

If any entry on the way has its valid bit clear, the walk stops at that level and the requester sees a fault. That entry covers a whole subtree with no mapping behind it. On success the walker returns the physical address and the permission and status flags of the leaf entry.

The walker serves one request at a time. It tolerates any stall on the memory request side and any delay on the read data.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is low, and in the first cycle after it, `busy`, `done` and `mem_req_valid` are low and `req_ready` is high. A reset in the middle of a walk abandons the walk.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low while a walk is in progress, and requests offered during that time are dropped.
- R3: The read for level k (k = 0 first) goes to table_base + 8 × idx_k. idx_k is the 9-bit slice `req_va[12+9*(3-k)+8 : 12+9*(3-k)]`, so level 0 uses bits 47:39 and level 3 uses bits 20:12. The level-0 table_base is `req_root[39:12]` followed by twelve zero bits, and the low 12 bits of `req_root` are ignored.
- R4: An entry is valid when bit 0 is set. A valid entry at levels 0 to 2 gives the next table_base as entry bits 39:12 followed by twelve zero bits. Entry bits 63:40 and 11:5 are ignored.
- R5: Each level issues exactly one read. `mem_req_valid` and `mem_req_addr` are held steady until `mem_req_ready` is seen high. A walk makes at most 4 reads.
- R6: After a read is accepted, the walker waits any number of cycles for `mem_rsp_valid`. A `mem_rsp_valid` pulse that arrives while no read is outstanding is ignored.
- R7: An entry with bit 0 clear, at any level, ends the walk. The walker reports `fault`=1 and `fault_level` = that level, makes no further reads, and sets `rsp_pa` and all flags to 0.
- R8: A valid level-3 entry ends the walk with `fault`=0. `rsp_pa` is entry[39:12] concatenated with `req_va[11:0]`. The flags are `rsp_read` = bit 1, `rsp_write` = bit 2, `rsp_dirty` = bit 3 and `rsp_use` = bit 4, and `fault_level` = 3.
- R9: `busy` is high from the cycle after acceptance until the walk ends. `done` is high for exactly one cycle, in which `busy` is already low.
- R10: The result outputs (`fault`, `fault_level`, `rsp_pa`, flags) keep their values until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 48 | Virtual address to translate |
| req_root | input | 40 | Physical address of the root table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Last walk hit an invalid entry |
| fault_level | output | 2 | Level at which the last walk ended |
| rsp_pa | output | 40 | Translated physical address |
| rsp_read | output | 1 | Leaf read permission |
| rsp_write | output | 1 | Leaf write permission |
| rsp_dirty | output | 1 | Leaf dirty flag |
| rsp_use | output | 1 | Leaf use flag |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read back |

## Verification
The walk is tried with complete mappings whose leaves carry different flag mixes and extreme page numbers. It is also tried with missing entries at each of the four levels, so that the fault level and the number of reads show where the walk stopped. An all-ones virtual address drives the largest index at every level. A root address with non-zero low bits, and entries with reserved upper bits set, show that only the specified fields steer the walk. Varying memory stall and latency settings separate handshake timing from address content. Directed cases cover requests during a walk, stray read data, reset in mid-walk, and result holding.

// File: rtl/pgwalk_pkg.sv
// Shared types and entry field positions for the page table walker.
package pgwalk_pkg;

    // Walker control states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_state_t;

    // Bit positions inside a table entry.
    localparam int ENT_VALID = 0;
    localparam int ENT_READ  = 1;
    localparam int ENT_WRITE = 2;
    localparam int ENT_DIRTY = 3;
    localparam int ENT_USE   = 4;

    // Leaf permission and status flags.
    typedef struct packed {
        logic read;
        logic write;
        logic dirty;
        logic used;
    } perm_t;

endpackage

// File: rtl/pgwalk_index.sv
// Entry address generator.
// Picks the index field of the current level out of the virtual page number
// and adds it, scaled by the entry size, to the current table base.
// Assumes: the table base is page aligned (given as a page number) and
// level < LEVELS.
module pgwalk_index #(
    parameter int VPN_W  = 36,
    parameter int PPN_W  = 28,
    parameter int PA_W   = 40,
    parameter int OFS_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int ENT_SH = 3,
    parameter int LVL_W  = 2
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    input  logic [PPN_W-1:0] table_ppn,
    output logic [PA_W-1:0]  ent_addr
);

    logic [IDX_W-1:0] idx_tab [LEVELS];
    logic [IDX_W-1:0] idx_sel;
    logic [PA_W-1:0]  table_base;
    logic [PA_W-1:0]  idx_offset;

    // Level 0 takes the most significant slice, the last level the least.
    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_slice
            assign idx_tab[g] = vpn[IDX_W*(LEVELS-1-g) +: IDX_W];
        end
    endgenerate

    // Select the slice belonging to the current level.
    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) begin
                idx_sel = idx_tab[i];
            end
        end
    end

    // Base plus index times entry size.
    always_comb begin
        table_base = {table_ppn, {OFS_W{1'b0}}};
        idx_offset = PA_W'(idx_sel) << ENT_SH;
        ent_addr   = table_base + idx_offset;
    end

endmodule

// File: rtl/pgwalk_decode.sv
// Table entry decoder.
// Splits a raw entry read from memory into its valid bit, its leaf flags and
// the page number it carries (next table or leaf page).
// Assumes: the page number lives in bits [PA_W-1:OFS_W]; other upper bits
// and the spare low bits carry no meaning for the walk.
module pgwalk_decode
    import pgwalk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PA_W   = 40,
    parameter int OFS_W  = 12,
    parameter int PPN_W  = 28
) (
    input  logic [DATA_W-1:0] entry,
    output logic              ent_valid,
    output perm_t             ent_perm,
    output logic [PPN_W-1:0]  ent_ppn
);

    logic unused_entry_bits;

    // Field extraction.
    always_comb begin
        ent_valid      = entry[ENT_VALID];
        ent_perm.read  = entry[ENT_READ];
        ent_perm.write = entry[ENT_WRITE];
        ent_perm.dirty = entry[ENT_DIRTY];
        ent_perm.used  = entry[ENT_USE];
        ent_ppn        = entry[PA_W-1:OFS_W];
    end

    // Bits that do not steer the walk.
    assign unused_entry_bits = ^{entry[DATA_W-1:PA_W], entry[OFS_W-1:ENT_USE+1]};

endmodule

// File: rtl/pgwalk_ctrl.sv
// Walk sequencer.
// Accepts a request while idle, issues one entry read per level, waits for
// the read data, and either descends, finishes on the last level, or stops
// on an invalid entry.
// Assumes: memory returns exactly one response per accepted read; response
// pulses outside the wait state are spurious and dropped.
module pgwalk_ctrl
    import pgwalk_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int PPN_W  = 28,
    parameter int LVL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic             ent_valid,
    input  logic [PPN_W-1:0] ent_ppn,
    output logic             req_ready,
    output logic             accept,
    output logic             busy,
    output logic             mem_req_valid,
    output logic [LVL_W-1:0] level,
    output logic [PPN_W-1:0] table_ppn,
    output logic             finish,
    output logic             finish_fault
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_t state;
    logic        rsp_take;
    logic        last_lvl;

    // Decode handshakes and end-of-walk conditions.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        busy          = (state != ST_IDLE);
        mem_req_valid = (state == ST_ISSUE);
        accept        = req_ready && req_valid;
        rsp_take      = (state == ST_WAIT) && mem_rsp_valid;
        last_lvl      = (level == LAST_LVL);
        finish        = rsp_take && (!ent_valid || last_lvl);
        finish_fault  = rsp_take && !ent_valid;
    end

    // State, level and current table base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            level     <= '0;
            table_ppn <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_ISSUE;
                        level     <= '0;
                        table_ppn <= root_ppn;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_valid || last_lvl) begin
                            state <= ST_IDLE;
                        end else begin
                            state     <= ST_ISSUE;
                            level     <= level + 1'b1;
                            table_ppn <= ent_ppn;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
// Multi-level page table walker, top level.
// Captures the virtual address of an accepted request, drives the sequencer,
// address generator and entry decoder, and registers the walk result.
// Assumes: tables are page sized and page aligned; the virtual address width
// equals offset bits plus one index field per level.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFS_W  = 12,
    parameter int PA_W   = 40,
    parameter int DATA_W = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [OFS_W+IDX_W*LEVELS-1:0]         req_va,
    input  logic [PA_W-1:0]                       req_root,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  fault,
    output logic [(LEVELS>1?$clog2(LEVELS):1)-1:0] fault_level,
    output logic [PA_W-1:0]                       rsp_pa,
    output logic                                  rsp_read,
    output logic                                  rsp_write,
    output logic                                  rsp_dirty,
    output logic                                  rsp_use,
    output logic                                  mem_req_valid,
    input  logic                                  mem_req_ready,
    output logic [PA_W-1:0]                       mem_req_addr,
    input  logic                                  mem_rsp_valid,
    input  logic [DATA_W-1:0]                     mem_rsp_data
);

    localparam int VPN_W  = IDX_W * LEVELS;
    localparam int PPN_W  = PA_W - OFS_W;
    localparam int ENT_SH = $clog2(DATA_W / 8);
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    logic [VPN_W-1:0] vpn_q;
    logic [OFS_W-1:0] ofs_q;
    logic [LVL_W-1:0] level;
    logic [PPN_W-1:0] table_ppn;
    logic             accept;
    logic             finish;
    logic             finish_fault;
    logic             ent_valid;
    perm_t            ent_perm;
    logic [PPN_W-1:0] ent_ppn;
    perm_t            perm_q;
    logic             unused_root_low;

    assign unused_root_low = ^req_root[OFS_W-1:0];

    // Sequencer.
    pgwalk_ctrl #(
        .LEVELS (LEVELS),
        .PPN_W  (PPN_W),
        .LVL_W  (LVL_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .root_ppn      (req_root[PA_W-1:OFS_W]),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_valid     (ent_valid),
        .ent_ppn       (ent_ppn),
        .req_ready     (req_ready),
        .accept        (accept),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .level         (level),
        .table_ppn     (table_ppn),
        .finish        (finish),
        .finish_fault  (finish_fault)
    );

    // Entry address generator.
    pgwalk_index #(
        .VPN_W  (VPN_W),
        .PPN_W  (PPN_W),
        .PA_W   (PA_W),
        .OFS_W  (OFS_W),
        .IDX_W  (IDX_W),
        .LEVELS (LEVELS),
        .ENT_SH (ENT_SH),
        .LVL_W  (LVL_W)
    ) u_index (
        .vpn       (vpn_q),
        .level     (level),
        .table_ppn (table_ppn),
        .ent_addr  (mem_req_addr)
    );

    // Entry decoder.
    pgwalk_decode #(
        .DATA_W (DATA_W),
        .PA_W   (PA_W),
        .OFS_W  (OFS_W),
        .PPN_W  (PPN_W)
    ) u_decode (
        .entry     (mem_rsp_data),
        .ent_valid (ent_valid),
        .ent_perm  (ent_perm),
        .ent_ppn   (ent_ppn)
    );

    // Hold the virtual address of the walk in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q <= '0;
            ofs_q <= '0;
        end else if (accept) begin
            vpn_q <= req_va[OFS_W+VPN_W-1:OFS_W];
            ofs_q <= req_va[OFS_W-1:0];
        end
    end

    // Register the result and the end-of-walk pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            fault       <= 1'b0;
            fault_level <= '0;
            rsp_pa      <= '0;
            perm_q      <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                fault       <= finish_fault;
                fault_level <= level;
                if (finish_fault) begin
                    rsp_pa <= '0;
                    perm_q <= '0;
                end else begin
                    rsp_pa <= {ent_ppn, ofs_q};
                    perm_q <= ent_perm;
                end
            end
        end
    end

    // Flag outputs.
    always_comb begin
        rsp_read  = perm_q.read;
        rsp_write = perm_q.write;
        rsp_dirty = perm_q.dirty;
        rsp_use   = perm_q.used;
    end

endmodule

// File: rtl/pgwalk_chk.sv
// Property checker for the walker, attached to every pgwalk_top instance.
// Keeps a count of reads made since the last accepted request.
module pgwalk_chk #(
    parameter int PA_W   = 40,
    parameter int LEVELS = 4
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   req_valid,
    input logic                                   req_ready,
    input logic                                   busy,
    input logic                                   done,
    input logic                                   fault,
    input logic [(LEVELS>1?$clog2(LEVELS):1)-1:0] fault_level,
    input logic [PA_W-1:0]                        rsp_pa,
    input logic                                   mem_req_valid,
    input logic                                   mem_req_ready,
    input logic [PA_W-1:0]                        mem_req_addr
);

    localparam int CNT_W = $clog2(LEVELS + 1) + 1;

    logic [CNT_W-1:0] rd_cnt;

    // Reads accepted by memory in the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
        end else if (req_valid && req_ready) begin
            rd_cnt <= '0;
        end else if (mem_req_valid && mem_req_ready) begin
            rd_cnt <= rd_cnt + 1'b1;
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy); // R2
    AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready); // R2
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid); // R5
    AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= CNT_W'(LEVELS)); // R5
    AST_FAULT_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (rd_cnt == CNT_W'(fault_level) + 1'b1)); // R7
    AST_LEAF_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (rd_cnt == CNT_W'(LEVELS))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(rsp_pa) && $stable(fault) && $stable(fault_level))); // R10

endmodule

bind pgwalk_top pgwalk_chk #(.PA_W(PA_W), .LEVELS(LEVELS)) u_chk (.*);

// File: tb/sim_pgwalk_top.sv
// Bench for pgwalk_top: sparse memory model with configurable stall and
// latency, a vector table of walks, then directed corner cases.
module sim_pgwalk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic [39:0] req_root = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_level;
    logic [39:0] rsp_pa;
    logic        rsp_read, rsp_write, rsp_dirty, rsp_use;
    logic        mem_req_valid, mem_req_ready;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    pgwalk_top u0 (.*);

    // Memory model.
    logic [63:0] mem [logic [39:0]];
    logic [39:0] rd_log [16];
    int          rd_total = 0;
    int          lat_cfg = 0;
    int          stall_cfg = 0;
    int          wait_cnt = 0;
    int          lat_cnt = 0;
    logic        pend = 1'b0;
    logic [63:0] pend_data = '0;
    logic        rsp_v = 1'b0;
    logic [63:0] rsp_d = '0;
    logic        spur = 1'b0;
    logic [63:0] spur_data = '0;

    function automatic logic [63:0] rd_mem(input logic [39:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    assign mem_req_ready = (wait_cnt >= stall_cfg);
    assign mem_rsp_valid = rsp_v | spur;
    assign mem_rsp_data  = rsp_v ? rsp_d : spur_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= 0;
            pend     <= 1'b0;
            rsp_v    <= 1'b0;
            lat_cnt  <= 0;
        end else begin
            rsp_v <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                rd_log[rd_total % 16] <= mem_req_addr;
                rd_total  <= rd_total + 1;
                pend      <= 1'b1;
                lat_cnt   <= lat_cfg;
                pend_data <= rd_mem(mem_req_addr);
                wait_cnt  <= 0;
            end else if (mem_req_valid) begin
                wait_cnt <= wait_cnt + 1;
            end else begin
                wait_cnt <= 0;
            end
            if (pend) begin
                if (lat_cnt == 0) begin
                    rsp_v <= 1'b1;
                    rsp_d <= pend_data;
                    pend  <= 1'b0;
                end else begin
                    lat_cnt <= lat_cnt - 1;
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: run did not end, actual cycles=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [47:0] va;
        logic [39:0] root;
        logic        flt;
        logic [1:0]  lvl;
        logic [39:0] pa;
        logic [3:0]  perm;   // {read, write, dirty, use}
        logic [3:0]  lat;
        logic [3:0]  stall;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{48'h0080_8060_4ABC, 40'h00_0001_0000, 1'b0, 2'd3, 40'h00_1234_5ABC, 4'b1000, 4'd0, 4'd0},
        '{48'h0080_8060_5123, 40'h00_0001_0000, 1'b0, 2'd3, 40'hFF_FFFF_F123, 4'b1111, 4'd1, 4'd0},
        '{48'h0080_8060_6000, 40'h00_0001_0000, 1'b1, 2'd3, 40'h0,            4'b0000, 4'd3, 4'd2},
        '{48'h0380_0000_0000, 40'h00_0001_0000, 1'b1, 2'd0, 40'h0,            4'b0000, 4'd0, 4'd1},
        '{48'h0082_4000_0000, 40'h00_0001_0000, 1'b1, 2'd1, 40'h0,            4'b0000, 4'd5, 4'd0},
        '{48'h0080_BFE0_0000, 40'h00_0001_0000, 1'b1, 2'd2, 40'h0,            4'b0000, 4'd2, 4'd3},
        '{48'hFFFF_FFFF_FFFF, 40'h00_0005_0000, 1'b0, 2'd3, 40'h00_ABCD_EFFF, 4'b0101, 4'd0, 4'd0},
        '{48'h0080_8060_4ABC, 40'h00_0005_0000, 1'b1, 2'd0, 40'h0,            4'b0000, 4'd1, 4'd1},
        '{48'h0080_8060_4ABC, 40'h00_0001_0FFF, 1'b0, 2'd3, 40'h00_1234_5ABC, 4'b1000, 4'd4, 4'd4}
    };

    // Independent model of the read addresses (R3, R4, R7).
    task automatic check_reads(input logic [47:0] va, input logic [39:0] root, input int base);
        logic [39:0] tbl;
        logic [39:0] a;
        logic [63:0] e;
        int          nexp;
        tbl  = {root[39:12], 12'h000};
        nexp = 4;
        for (int k = 0; k < 4; k++) begin
            a = tbl + {31'b0, va[12 + 9*(3-k) +: 9]} * 40'd8;
            if (k < rd_total - base)
                chk(rd_log[(base + k) % 16] == a, "R3 entry address", {24'b0, rd_log[(base + k) % 16]}, {24'b0, a});
            e = rd_mem(a);
            if (!e[0]) begin
                nexp = k + 1;
                break;
            end
            tbl = {e[39:12], 12'h000};
        end
        chk((rd_total - base) == nexp, "R5 read count", 64'(rd_total - base), 64'(nexp));
    endtask

    // Start a walk and wait for its end; leaves time at the done cycle.
    task automatic start_and_wait(input logic [47:0] va, input logic [39:0] root, output logic ok);
        int n;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        req_root  = root;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", {63'b0, busy}, 64'h1);
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        ok = done;
        chk(done == 1'b1, "R9 done reached", {63'b0, done}, 64'h1);
    endtask

    task automatic run_vec(input vec_t v);
        int   base;
        logic ok;
        lat_cfg   = int'(v.lat);
        stall_cfg = int'(v.stall);
        base      = rd_total;
        start_and_wait(v.va, v.root, ok);
        if (ok) begin
            chk(busy == 1'b0, "R9 busy low at done", {63'b0, busy}, 64'h0);
            chk(fault == v.flt, v.flt ? "R7 fault flag" : "R8 fault flag", {63'b0, fault}, {63'b0, v.flt});
            chk(fault_level == v.lvl, v.flt ? "R7 fault level" : "R8 level", {62'b0, fault_level}, {62'b0, v.lvl});
            chk(rsp_pa == v.pa, v.flt ? "R7 pa cleared" : "R8 physical address", {24'b0, rsp_pa}, {24'b0, v.pa});
            chk({rsp_read, rsp_write, rsp_dirty, rsp_use} == v.perm, "R8 flags",
                {60'b0, rsp_read, rsp_write, rsp_dirty, rsp_use}, {60'b0, v.perm});
            check_reads(v.va, v.root, base);
            @(negedge clk);
            chk(done == 1'b0, "R9 done single pulse", {63'b0, done}, 64'h0);
        end
    endtask

    initial begin
        logic        ok;
        logic [39:0] pa_hold;
        int          base;
        int          dones;

        // Tables rooted at page 0x10 (R4: reserved upper bits in one entry).
        mem[40'h00_0001_0008] = 64'h0000_0000_0002_0001;
        mem[40'h00_0002_0010] = 64'hFFF0_0000_0003_0001;
        mem[40'h00_0003_0018] = 64'h0000_0000_0004_0001;
        mem[40'h00_0004_0020] = 64'h0000_0000_1234_5003;
        mem[40'h00_0004_0028] = 64'h0000_00FF_FFFF_F01F;
        mem[40'h00_0004_0030] = 64'h0000_0000_0777_7FFE;
        // Tables rooted at page 0x50, reached through index 0x1FF everywhere.
        mem[40'h00_0005_0FF8] = 64'h0000_0000_0006_0001;
        mem[40'h00_0006_0FF8] = 64'h0000_0000_0006_1001;
        mem[40'h00_0006_1FF8] = 64'h0000_0000_0006_2001;
        mem[40'h00_0006_2FF8] = 64'h0000_0000_ABCD_E015;

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", {63'b0, busy}, 64'h0);
        chk(done == 1'b0, "R1 done in reset", {63'b0, done}, 64'h0);
        chk(mem_req_valid == 1'b0, "R1 no read in reset", {63'b0, mem_req_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {63'b0, req_ready}, 64'h1);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R10: results held while idle.
        pa_hold = rsp_pa;
        repeat (5) @(negedge clk);
        chk(rsp_pa == pa_hold, "R10 result held", {24'b0, rsp_pa}, {24'b0, pa_hold});

        // R6: stray read data while idle is ignored.
        spur_data = 64'h0;
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        chk(done == 1'b0 && busy == 1'b0, "R6 stray data idle", {62'b0, done, busy}, 64'h0);
        @(negedge clk);
        chk(done == 1'b0, "R6 no done from stray data", {63'b0, done}, 64'h0);
        chk(rsp_pa == pa_hold, "R10 result held after stray data", {24'b0, rsp_pa}, {24'b0, pa_hold});

        // R6: stray data during a stalled read, then a slow response.
        lat_cfg   = 7;
        stall_cfg = 4;
        base      = rd_total;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = 48'hFFFF_FFFF_FFFF;
        req_root  = 40'h00_0005_0000;
        @(negedge clk);
        req_valid = 1'b0;
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        dones = 0;
        for (int n = 0; n < 400 && !done; n++) @(negedge clk);
        chk(done == 1'b1 && fault == 1'b0, "R6 stray data mid-walk ignored", {62'b0, done, fault}, 64'h2);
        chk(rsp_pa == 40'h00_ABCD_EFFF, "R6 slow walk address", {24'b0, rsp_pa}, 64'hABCDEFFF);
        check_reads(48'hFFFF_FFFF_FFFF, 40'h00_0005_0000, base);

        // R2: requests offered during a walk are dropped.
        lat_cfg   = 3;
        stall_cfg = 1;
        base      = rd_total;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = 48'h0080_8060_4ABC;
        req_root  = 40'h00_0001_0000;
        @(negedge clk);
        req_va = 48'h0380_0000_0000;
        chk(req_ready == 1'b0, "R2 not ready while busy", {63'b0, req_ready}, 64'h0);
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        dones = 0;
        for (int n = 0; n < 120; n++) begin
            @(negedge clk);
            if (done) begin
                dones++;
                chk(fault == 1'b0 && rsp_pa == 40'h00_1234_5ABC, "R2 first request result",
                    {23'b0, fault, rsp_pa}, 64'h0_1234_5ABC);
            end
        end
        chk(dones == 1, "R2 single walk", 64'(dones), 64'h1);
        chk((rd_total - base) == 4, "R2 read count", 64'(rd_total - base), 64'h4);

        // R1: reset in the middle of a walk.
        lat_cfg   = 8;
        stall_cfg = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = 48'h0080_8060_5123;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && mem_req_valid == 1'b0, "R1 reset mid-walk", {62'b0, busy, mem_req_valid}, 64'h0);
        chk(rsp_pa == 40'h0 && fault == 1'b0, "R1 result cleared", {23'b0, fault, rsp_pa}, 64'h0);
        rst_n = 1'b1;
        repeat (15) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1 abandoned walk stays idle", {62'b0, done, busy}, 64'h0);

        // Walk again after reset.
        run_vec(VECS[1]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule